// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block works out which column an SDRAM burst touches on each clock. A mode word is loaded through a strobe and fixes three things: the burst length (1, 2, 4, 8 or a whole row), the ordering inside a burst (wrapping count or XOR interleave), and whether writes are forced down to a single beat. A start strobe brings in a starting column and a read/write flag. From the next clock on, the block presents one column address per cycle, with a valid flag and a flag that marks the final beat.

For lengths 2, 4 and 8 the column is split in two. The upper bits name an aligned block and stay fixed. The low bits walk through the block in the chosen order. A whole-row burst counts through every column, wraps at the end of the row and runs until a terminate input stops it. The block rejects mode words it cannot honour by raising an error flag. While that flag is high, no burst can be started.

Top module: `burst_col_gen`

## Requirements
- R1: After reset the mode is length 1, wrapping order, single-beat override off, and `modeError` is 0. A word presented with `loadMode` is taken at that clock edge, and it governs every burst started from the following cycle on.
- R2: Length field `modeWord[2:0]` decodes as 000 = 1 beat, 001 = 2, 010 = 4, 011 = 8, 111 = whole row.
- R3: With `modeWord[3]` = 0 and a length L of 2, 4 or 8, beat k addresses column (startCol with its low log2(L) bits replaced by (startOffset + k) mod L). The bits above the block do not change during the burst.
- R4: With `modeWord[3]` = 1 and a length L of 2, 4 or 8, the in-block offset of beat k is startOffset XOR k.
- R5: With length 1, the whole starting column is output once, and `modeWord[3]` has no effect.
- R6: With length 111 the address starts at startCol and rises by one per beat, wrapping from 2^COL_W-1 to 0. The burst runs until terminate, and `lastBeat` stays low throughout.
- R7: `modeError` goes high at the edge that loads a length code of 100, 101 or 110, a word with `modeWord[8:7]` not equal to 00, or a whole-row word with `modeWord[3]` = 1. A later valid word clears it. While `modeError` is high, `startBurst` is ignored.
- R8: With `modeWord[9]` = 1, a burst started with `isWrite` = 1 is one beat at startCol. A burst started with `isWrite` = 0 uses the programmed length.
- R9: `startBurst` is sampled at a clock edge. Beat 0 (startCol) is shown in the cycle after that edge, and each further beat follows one clock later.
- R10: `lastBeat` is high exactly on the final beat of a fixed-length burst. `colValid` is low in the next cycle unless a new burst is started.
- R11: `terminate` sampled at an edge makes `colValid` low after that edge, for any burst length. If `startBurst` is sampled at the same edge, the start wins.
- R12: A `startBurst` during an active burst drops the old burst, and the next cycle shows beat 0 of the new one.
- R13: While `colValid` is low, `colAddr` and `lastBeat` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| loadMode | input | 1 | Load `modeWord` into the mode register |
| modeWord | input | MODE_W | Mode word: [2:0] length, [3] order, [8:7] operating mode, [9] single-beat writes |
| startBurst | input | 1 | Begin a burst at `startCol` |
| startCol | input | COL_W | Starting column |
| isWrite | input | 1 | 1 when the burst being started is a write |
| terminate | input | 1 | Stop the current burst |
| colAddr | output | COL_W | Column address of the current beat |
| colValid | output | 1 | A beat is being presented |
| lastBeat | output | 1 | The current beat is the final one of a fixed-length burst |
| modeError | output | 1 | The loaded mode word is reserved or unsupported |

## Verification
The assertions assume that `loadMode` is never asserted while a burst is running. The latched block mask is only trusted because the mode does not change under an active burst. The stimulus therefore loads a mode word only while the generator is idle, holds each strobe for exactly one clock, and raises terminate only during bursts. Restarts are only issued inside a running burst of the same mode, so every address the scoreboard expects is derived from a single known mode word.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture start column, clear beat index
    logic step;   // advance beat index by one
  } burstStrobe_t;

  // decoded mode register contents
  typedef struct packed {
    logic       fullPage;
    logic [1:0] lenLog;
    logic       interleave;
    logic       wbSingle;
  } modeCfg_t;

  localparam int LEN_LSB  = 0;
  localparam int TYPE_BIT = 3;
  localparam int OP_LSB   = 7;
  localparam int WB_BIT   = 9;

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
  import burst_col_pkg::*;
#(
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadMode,
  input  logic [MODE_W-1:0] modeWord,
  output modeCfg_t          cfg,
  output logic              modeError
);

  modeCfg_t decCfg;
  logic     decErr;
  logic     unusedMode;

  assign unusedMode = ^{modeWord[MODE_W-1:WB_BIT+1], modeWord[OP_LSB-1:TYPE_BIT+1]};

  always_comb begin
    decCfg            = '0;
    decErr            = 1'b0;
    decCfg.interleave = modeWord[TYPE_BIT];
    decCfg.wbSingle   = modeWord[WB_BIT];
    unique case (modeWord[LEN_LSB+2:LEN_LSB])
      3'b000:  decCfg.lenLog = 2'd0;
      3'b001:  decCfg.lenLog = 2'd1;
      3'b010:  decCfg.lenLog = 2'd2;
      3'b011:  decCfg.lenLog = 2'd3;
      3'b111:  decCfg.fullPage = 1'b1;
      default: decErr = 1'b1;
    endcase
    if (modeWord[OP_LSB+1:OP_LSB] != 2'b00) decErr = 1'b1;
    if (decCfg.fullPage && decCfg.interleave) decErr = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg       <= '0;
      modeError <= 1'b0;
    end else if (loadMode) begin
      cfg       <= decCfg;
      modeError <= decErr;
    end
  end

  AST_RESERVED_LEN_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (loadMode && modeWord[2] && !(&modeWord[1:0])) |=> modeError); // R7

  AST_OPMODE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (loadMode && (modeWord[OP_LSB+1:OP_LSB] != 2'b00)) |=> modeError); // R7

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startBurst,
  input  logic             isWrite,
  input  logic             terminate,
  input  modeCfg_t         cfg,
  input  logic             modeError,
  input  logic [COL_W-1:0] beatIdx,
  output burstStrobe_t     strb,
  output logic [COL_W-1:0] blockMask,
  output logic             interleave,
  output logic             active,
  output logic             lastNow
);

  logic             startOk;
  logic             singleEff;
  logic [COL_W-1:0] nextMask;
  logic             fullQ;

  assign startOk   = startBurst && !modeError;
  assign singleEff = (isWrite && cfg.wbSingle) || (!cfg.fullPage && cfg.lenLog == 2'd0);

  always_comb begin
    if (singleEff)         nextMask = '0;
    else if (cfg.fullPage) nextMask = '1;
    else                   nextMask = (COL_W'(1) << cfg.lenLog) - COL_W'(1);
  end

  assign strb.load = startOk;
  assign strb.step = active && !startOk;
  assign lastNow   = active && !fullQ && (beatIdx == blockMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blockMask  <= '0;
      interleave <= 1'b0;
      fullQ      <= 1'b0;
    end else if (startOk) begin
      blockMask  <= nextMask;
      interleave <= cfg.interleave && !singleEff;
      fullQ      <= cfg.fullPage && !singleEff;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          active <= 1'b0;
    else if (startOk)   active <= 1'b1;
    else if (terminate) active <= 1'b0;
    else if (lastNow)   active <= 1'b0;
  end

  AST_START_GOES_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (startBurst && !modeError) |=> active); // R9

  AST_LAST_ENDS_BURST: assert property (@(posedge clk) disable iff (!rstN)
    (lastNow && !startBurst) |=> !active); // R10

  AST_TERM_ENDS_BURST: assert property (@(posedge clk) disable iff (!rstN)
    (terminate && !startBurst) |=> !active); // R11

  AST_ERROR_BLOCKS_START: assert property (@(posedge clk) disable iff (!rstN)
    (modeError && !active) |=> !active); // R7

endmodule

// File: rtl/burst_addr_path.sv
module burst_addr_path
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  burstStrobe_t     strb,
  input  logic [COL_W-1:0] startCol,
  input  logic [COL_W-1:0] blockMask,
  input  logic             interleave,
  input  logic             active,
  output logic [COL_W-1:0] beatIdx,
  output logic [COL_W-1:0] colAddr
);

  logic [COL_W-1:0] startQ;
  logic [COL_W-1:0] offRaw;
  logic [COL_W-1:0] addrRaw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ  <= '0;
      beatIdx <= '0;
    end else if (strb.load) begin
      startQ  <= startCol;
      beatIdx <= '0;
    end else if (strb.step) begin
      beatIdx <= beatIdx + COL_W'(1);
    end
  end

  assign offRaw  = interleave ? (startQ ^ beatIdx) : (startQ + beatIdx);
  assign addrRaw = (startQ & ~blockMask) | (offRaw & blockMask);
  assign colAddr = active ? addrRaw : '0;

  AST_FIRST_BEAT_IS_START: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (colAddr == $past(startCol))); // R9

  AST_BLOCK_BITS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> $stable(addrRaw & ~blockMask)); // R3

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadMode,
  input  logic [MODE_W-1:0] modeWord,
  input  logic              startBurst,
  input  logic [COL_W-1:0]  startCol,
  input  logic              isWrite,
  input  logic              terminate,
  output logic [COL_W-1:0]  colAddr,
  output logic              colValid,
  output logic              lastBeat,
  output logic              modeError
);

  modeCfg_t         cfg;
  burstStrobe_t     strb;
  logic [COL_W-1:0] blockMask;
  logic [COL_W-1:0] beatIdx;
  logic             interleave;
  logic             active;
  logic             lastNow;

  burst_mode_reg #(.MODE_W(MODE_W)) u_mode (
    .clk(clk), .rstN(rstN), .loadMode(loadMode), .modeWord(modeWord),
    .cfg(cfg), .modeError(modeError)
  );

  burst_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startBurst(startBurst), .isWrite(isWrite),
    .terminate(terminate), .cfg(cfg), .modeError(modeError), .beatIdx(beatIdx),
    .strb(strb), .blockMask(blockMask), .interleave(interleave),
    .active(active), .lastNow(lastNow)
  );

  burst_addr_path #(.COL_W(COL_W)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .startCol(startCol),
    .blockMask(blockMask), .interleave(interleave), .active(active),
    .beatIdx(beatIdx), .colAddr(colAddr)
  );

  assign colValid = active;
  assign lastBeat = lastNow;

  AST_LAST_ONLY_WHEN_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !colValid |-> (!lastBeat && colAddr == '0)); // R13

endmodule

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;

  localparam int COL_W  = 9;
  localparam int MODE_W = 12;
  localparam int ROW    = 1 << COL_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              loadMode = 1'b0;
  logic [MODE_W-1:0] modeWord = '0;
  logic              startBurst = 1'b0;
  logic [COL_W-1:0]  startCol = '0;
  logic              isWrite = 1'b0;
  logic              terminate = 1'b0;
  logic [COL_W-1:0]  colAddr;
  logic              colValid;
  logic              lastBeat;
  logic              modeError;

  int checks = 0;
  int errors = 0;

  int    qAddr[$];
  bit    qLast[$];
  string qReq[$];

  always #10 clk = ~clk;  // 50 MHz

  burst_col_gen #(.COL_W(COL_W), .MODE_W(MODE_W)) u_dut (
    .clk(clk), .rstN(rstN), .loadMode(loadMode), .modeWord(modeWord),
    .startBurst(startBurst), .startCol(startCol), .isWrite(isWrite),
    .terminate(terminate), .colAddr(colAddr), .colValid(colValid),
    .lastBeat(lastBeat), .modeError(modeError)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected column for beat k; len 0 means whole row
  function automatic int expCol(input int st, input int k, input int len, input bit inter);
    int base, off;
    if (len == 0) return (st + k) % ROW;
    off  = st % len;
    base = st - off;
    return inter ? base + (off ^ k) : base + ((off + k) % len);
  endfunction

  // monitor: scoreboard pop on every valid beat, idle check otherwise
  always @(negedge clk) begin
    if (rstN) begin
      if (colValid) begin
        if (qAddr.size() == 0) begin
          chk(1'b0, "R7/R10 unexpected beat", int'(colAddr), -1);
        end else begin
          int    ea;
          bit    el;
          string er;
          ea = qAddr.pop_front();
          el = qLast.pop_front();
          er = qReq.pop_front();
          chk(int'(colAddr) == ea && lastBeat == el, er,
              (int'(lastBeat) << 16) | int'(colAddr), (int'(el) << 16) | ea);
        end
      end else begin
        chk(colAddr == '0 && !lastBeat, "R13 idle outputs",
            (int'(lastBeat) << 16) | int'(colAddr), 0);
      end
    end
  end

  task automatic setMode(input int word, input bit expErr, input string req);
    loadMode = 1'b1;
    modeWord = MODE_W'(word);
    @(posedge clk); #1;
    loadMode = 1'b0;
    chk(modeError == expErr, req, int'(modeError), int'(expErr));
  endtask

  // endMode: 0 natural end, 1 terminate after nBeats, 2 leave running for restart
  task automatic doBurst(input int st, input bit wr, input int len, input bit inter,
                         input int nBeats, input int endMode, input string req);
    for (int k = 0; k < nBeats; k++) begin
      qAddr.push_back(expCol(st, k, len, inter));
      qLast.push_back(len > 0 && k == len - 1);
      qReq.push_back(req);
    end
    startBurst = 1'b1;
    startCol   = COL_W'(st);
    isWrite    = wr;
    @(posedge clk); #1;
    startBurst = 1'b0;
    if (nBeats > 1) repeat (nBeats - 1) begin
      @(posedge clk); #1;
    end
    if (endMode == 1) begin
      terminate = 1'b1;
      @(posedge clk); #1;
      terminate = 1'b0;
      chk(!colValid && qAddr.size() == 0, {req, " R11 ended by terminate"},
          int'(colValid), 0);
    end else if (endMode == 0) begin
      @(posedge clk); #1;
      chk(!colValid && qAddr.size() == 0, {req, " R10 burst complete"},
          qAddr.size() + int'(colValid), 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!colValid && !modeError && !lastBeat, "R1 reset state",
        int'({colValid, modeError, lastBeat}), 0);
    rstN = 1'b1;
    @(posedge clk); #1;

    // R1 R5: default mode gives a single beat
    doBurst(9'h113, 1'b0, 1, 1'b0, 1, 0, "R1 default single");

    // R2 R3: length 8 wrapping
    setMode(12'h003, 1'b0, "R1 load len8");
    doBurst(9'h015, 1'b0, 8, 1'b0, 8, 0, "R3 len8 wrap");
    // R4: length 8 interleaved
    setMode(12'h00B, 1'b0, "R1 load len8 xor");
    doBurst(9'h1D5, 1'b0, 8, 1'b1, 8, 0, "R4 len8 xor");
    // R2: lengths 4 and 2
    setMode(12'h002, 1'b0, "R1 load len4");
    doBurst(9'h00E, 1'b0, 4, 1'b0, 4, 0, "R2 len4 wrap");
    setMode(12'h00A, 1'b0, "R1 load len4 xor");
    doBurst(9'h0AD, 1'b1, 4, 1'b1, 4, 0, "R4 len4 xor");
    setMode(12'h001, 1'b0, "R1 load len2");
    doBurst(9'h107, 1'b0, 2, 1'b0, 2, 0, "R2 len2 wrap");
    // R5: length 1 with order bit set
    setMode(12'h008, 1'b0, "R1 load len1 xor bit");
    doBurst(9'h1AB, 1'b0, 1, 1'b0, 1, 0, "R5 len1 ignores order");

    // R6: whole row, crosses the row end, ended by terminate
    setMode(12'h007, 1'b0, "R1 load full row");
    doBurst(9'h1FD, 1'b0, 0, 1'b0, 6, 1, "R6 full row wrap");

    // R8: single-beat writes, reads keep length 8
    setMode(12'h203, 1'b0, "R1 load write single");
    doBurst(9'h022, 1'b1, 1, 1'b0, 1, 0, "R8 write one beat");
    doBurst(9'h022, 1'b0, 8, 1'b0, 8, 0, "R8 read eight beats");

    // R11: terminate a fixed burst early
    setMode(12'h003, 1'b0, "R1 load len8 again");
    doBurst(9'h040, 1'b0, 8, 1'b0, 3, 1, "R11 early stop");

    // R12: restart inside a running burst
    doBurst(9'h030, 1'b0, 8, 1'b0, 2, 2, "R12 first burst");
    doBurst(9'h055, 1'b0, 8, 1'b0, 8, 0, "R12 second burst");

    // R7: reserved and unsupported words; starts ignored
    setMode(12'h004, 1'b1, "R7 len code 100");
    doBurst(9'h010, 1'b0, 1, 1'b0, 0, 0, "R7 start ignored");
    setMode(12'h006, 1'b1, "R7 len code 110");
    setMode(12'h083, 1'b1, "R7 opmode bit");
    doBurst(9'h011, 1'b0, 1, 1'b0, 0, 0, "R7 start ignored opmode");
    setMode(12'h00F, 1'b1, "R7 full row xor");
    setMode(12'h003, 1'b0, "R7 error cleared");
    doBurst(9'h01A, 1'b0, 8, 1'b0, 8, 0, "R7 after clear");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule